// File: doc/BRIEF.md
# Erasable PROM Behavioural Model

A synthesizable, clock-based stand-in for a UV-erasable 8-bit-wide PROM, meant to sit in a testbench as the target of a programmer or a boot loader. It takes the active-low chip enable, output enable and program strobe pins. It also takes two flags that stand for analog conditions: the raised programming supply and the overvoltage on address line 9. From these it selects one of seven modes: standby, program inhibit, output disable, program, read, program verify and identification.

In place of a tri-state driver the model drives a data bus together with a separate drive-enable. It drives zero whenever it does not drive a word. Programming works like the real cell and can only clear bits. Only the erase input, or reset, brings a word back to all ones. A two-byte identification ROM replaces the array when the overvoltage flag is raised. A program strobe held low for too long raises a sticky error and stops writing.

The array depth is set by `ADDR_W`. The default of 11 keeps elaboration small. `ADDR_W = 13` gives the full 8192-word part.

Top module: `uvprom_model`

## Requirements
- R1: After reset, and after any clock edge with `erase` high, every word reads back as all ones (0xFF).
- R2: A program write stores the old word AND `din`, so a 1 in `din` keeps the stored bit and a 0 clears it. A cleared bit is never set again by a write.
- R3: Standby and inhibit: while `ce_n` is 1, `dout_en` is 0 one cycle later and `dout` is 0, for either level of `oe_n`.
- R4: Output disable: while `ce_n` is 0 and `oe_n` is 1, `dout_en` is 0 one cycle later.
- R5: Read: with `ce_n`=0, `oe_n`=0 and `vpp_hi`=0, `dout_en` is 1 one cycle later and `dout` returns the word at `addr`. `pgm_n` has no effect while `oe_n` is 0.
- R6: Program: each clock edge at which `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0 writes `din` into the word at `addr`. A low `pgm_n` with `vpp_hi`=0 writes nothing.
- R7: Verify: with `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, the stored word is driven the same way as in read.
- R8: Inhibit: with `vpp_hi`=1 and `ce_n`=1, a low `pgm_n` writes nothing and the bus is not driven.
- R9: Identification: with `a9_hv`=1 and `vpp_hi`=0, ce/oe low, and every address bit other than bit 0 and bit 9 at 0, `dout` is 0x8F when bit 0 is 0 and 0xC2 when bit 0 is 1. With any other address bit set, the array word is read instead.
- R10: The first `PULSE_LIMIT` edges of one continuous program strobe write. Later edges of the same strobe do not write, and the first of them sets `pulse_err`. `pulse_err` stays 1 until reset.
- R11: `dout` carries the word only from the (`READ_LAT`+1)-th clock edge at which `addr`, `ce_n`, `oe_n`, `vpp_hi` and `a9_hv` hold the same values. Before that edge, and whenever `dout_en` is 0, `dout` is 0.
- R12: Erase wins over a program write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; also fills the array with ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Overvoltage present on address line 9 |
| erase | input | 1 | UV exposure: sets every cell to 1 |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data presented for programming |
| dout | output | DATA_W | Data bus value, zero when not valid |
| dout_en | output | 1 | Bus is driven (stands in for tri-state control) |
| pulse_err | output | 1 | Sticky over-long program strobe flag |

## Verification
Writes are tried with patterns that overlap, such as 0xA5 followed by 0x3C. The expected 0x24 can only come from an AND, so it tells a clearing write apart from a plain overwrite. A strobe with the supply flag low and a strobe with chip enable high are each followed by a read of the same word, which shows whether either wrote anything. The identification flag is tried with the two code addresses and with an address that has another bit set, which separates the code ROM from the array. An address change inside a read, a strobe held past its limit while `din` changes, and an erase together with a strobe cover the timing, the lockout and the priority.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_OUTOFF,
        MD_PROG,
        MD_READ,
        MD_VERIFY,
        MD_IDENT
    } prom_mode_e;

    localparam logic [7:0] MAKER_CODE  = 8'h8F;
    localparam logic [7:0] DEVICE_CODE = 8'hC2;

    localparam int HV_ADDR_BIT = 9;

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
    import uvprom_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       vpp_hi,
    input  logic       id_sel,
    output prom_mode_e mode,
    output logic       drive
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        end else if (oe_n) begin
            mode = vpp_hi ? MD_PROG : MD_OUTOFF;
        end else if (vpp_hi) begin
            mode = MD_VERIFY;
        end else if (id_sel) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
        drive = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
    end

endmodule

// File: rtl/uvprom_pulse_guard.sv
module uvprom_pulse_guard #(
    parameter int PULSE_LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic wr_ok,
    output logic err
);

    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(PULSE_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_ok = strobe && (st_q.cnt < LIMIT_V);
        if (strobe) begin
            if (st_q.cnt == LIMIT_V) begin
                st_d.err = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (wr_en) begin
            cells_q[addr] <= cells_q[addr] & wdata;
        end
    end

    assign rdata = cells_q[addr];

endmodule

// File: rtl/uvprom_model.sv
module uvprom_model
    import uvprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int READ_LAT    = 2,
    parameter int PULSE_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              pulse_err
);

    localparam int KEY_W = ADDR_W + 4;
    localparam int LAT_W = $clog2(READ_LAT + 2);
    localparam logic [LAT_W-1:0] LAT_V = LAT_W'(READ_LAT);
    localparam logic [ADDR_W-1:0] ID_MASK =
        ~((ADDR_W'(1) << HV_ADDR_BIT) | ADDR_W'(1));

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [LAT_W-1:0]  cnt;
        logic [DATA_W-1:0] dout;
        logic              en;
    } top_st_t;

    top_st_t st_d, st_q;

    prom_mode_e        mode;
    logic              drive;
    logic              id_sel;
    logic              prog_strobe;
    logic              wr_ok;
    logic              err;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] word;
    logic [KEY_W-1:0]  key_now;

    assign id_sel      = a9_hv && ((addr & ID_MASK) == '0);
    assign prog_strobe = (mode == MD_PROG) && !pgm_n;

    uvprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_sel (id_sel),
        .mode   (mode),
        .drive  (drive)
    );

    uvprom_pulse_guard #(
        .PULSE_LIMIT (PULSE_LIMIT)
    ) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (prog_strobe),
        .wr_ok  (wr_ok),
        .err    (err)
    );

    uvprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .wr_en (wr_ok),
        .addr  (addr),
        .wdata (din),
        .rdata (rdata)
    );

    always_comb begin
        st_d    = st_q;
        key_now = {addr, ce_n, oe_n, vpp_hi, a9_hv};
        if (mode == MD_IDENT) begin
            word = addr[0] ? DATA_W'(DEVICE_CODE) : DATA_W'(MAKER_CODE);
        end else begin
            word = rdata;
        end
        st_d.key = key_now;
        if (key_now != st_q.key) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LAT_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.en   = drive;
        st_d.dout = (drive && (st_d.cnt == LAT_V)) ? word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.dout;
    assign dout_en   = st_q.en;
    assign pulse_err = err;

endmodule

// File: rtl/uvprom_model_chk.sv
module uvprom_model_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              pulse_err
);

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    p_standby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);

    p_out_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !dout_en);

    p_read_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> dout_en);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err |=> pulse_err);

endmodule

bind uvprom_model uvprom_model_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .dout      (dout),
    .dout_en   (dout_en),
    .pulse_err (pulse_err)
);

// File: tb/uvprom_model_test.sv
module uvprom_model_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int LAT   = 2;
    localparam int LIMIT = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          pulse_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uvprom_model #(
        .ADDR_W (AW), .DATA_W (DW), .READ_LAT (LAT), .PULSE_LIMIT (LIMIT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .pgm_n (pgm_n),
        .vpp_hi (vpp_hi), .a9_hv (a9_hv), .erase (erase), .addr (addr),
        .din (din), .dout (dout), .dout_en (dout_en), .pulse_err (pulse_err)
    );

    // Behavioural reference
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW+3:0] ref_key;
    int            ref_cnt, ref_pcnt;
    logic          ref_err, ref_en;
    logic [DW-1:0] ref_dout;
    string         ref_tag = "R3";

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
            ref_key = '0; ref_cnt = 0; ref_pcnt = 0;
            ref_err = 1'b0; ref_en = 1'b0; ref_dout = '0;
        end else begin
            logic [AW+3:0] k;
            logic          out_mode, id_mode, prog_act;
            logic [DW-1:0] w;
            k = {addr, ce_n, oe_n, vpp_hi, a9_hv};
            ref_cnt = (k != ref_key) ? 0 : ((ref_cnt < LAT) ? ref_cnt + 1 : LAT);
            ref_key = k;
            out_mode = !ce_n && !oe_n;
            id_mode  = out_mode && !vpp_hi && a9_hv && ((addr & ~AW'('h201)) == 0);
            prog_act = !ce_n && oe_n && vpp_hi && !pgm_n;
            if (ce_n)          ref_tag = vpp_hi ? "R8" : "R3";
            else if (oe_n)     ref_tag = vpp_hi ? "R6" : "R4";
            else if (vpp_hi)   ref_tag = "R7";
            else if (id_mode)  ref_tag = "R9";
            else               ref_tag = "R5";
            w = id_mode ? (addr[0] ? 8'hC2 : 8'h8F) : ref_mem[addr];
            ref_en   = out_mode;
            ref_dout = (out_mode && ref_cnt == LAT) ? w : '0;
            if (erase) begin
                for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
            end else if (prog_act && ref_pcnt < LIMIT) begin
                ref_mem[addr] = ref_mem[addr] & din;
            end
            if (prog_act && ref_pcnt == LIMIT) ref_err = 1'b1;
            ref_pcnt = prog_act ? ((ref_pcnt < LIMIT) ? ref_pcnt + 1 : LIMIT) : 0;
            #(CLK_PERIOD / 4);
            chk({ref_tag, "/R11 dout"}, dout, ref_dout);
            chk({ref_tag, " dout_en"}, {7'd0, dout_en}, {7'd0, ref_en});
            chk("R10 pulse_err", {7'd0, pulse_err}, {7'd0, ref_err});
        end
    end

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0; erase = 1'b0;
    endtask

    task automatic read_word(input logic [AW-1:0] a, input logic hv,
                             input logic [DW-1:0] exp, input string tag);
        ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; vpp_hi = 1'b0; a9_hv = hv; addr = a;
        repeat (LAT + 1) @(negedge clk);
        chk(tag, dout, exp);
        chk({tag, " en"}, {7'd0, dout_en}, 8'd1);
        idle();
        @(negedge clk);
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic vpp, input logic ce, input int n);
        ce_n = ce; oe_n = 1'b1; vpp_hi = vpp; addr = a; din = d; pgm_n = 1'b0;
        repeat (n) @(negedge clk);
        pgm_n = 1'b1;
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R3 reset dout", dout, 8'h00);
        chk("R3 reset en", {7'd0, dout_en}, 8'd0);
        chk("R10 reset err", {7'd0, pulse_err}, 8'd0);
        read_word(11'h123, 1'b0, 8'hFF, "R1 blank word");

        // R6 program, R7 verify, R2 clear-only, R5 read
        strobe(11'h005, 8'hA5, 1'b1, 1'b0, 2);
        ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b1; addr = 11'h005;
        repeat (LAT + 1) @(negedge clk);
        chk("R7 verify", dout, 8'hA5);
        idle(); @(negedge clk);
        strobe(11'h005, 8'h3C, 1'b1, 1'b0, 1);
        read_word(11'h005, 1'b0, 8'h24, "R2 and-write");
        // R5: pgm_n low while reading changes nothing
        ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b0; din = 8'h00; addr = 11'h005;
        repeat (LAT + 1) @(negedge clk);
        chk("R5 read with pgm low", dout, 8'h24);
        idle(); @(negedge clk);

        // R6 no supply, R8 inhibit
        strobe(11'h006, 8'h00, 1'b0, 1'b0, 3);
        read_word(11'h006, 1'b0, 8'hFF, "R6 no supply no write");
        ce_n = 1'b1; vpp_hi = 1'b1; oe_n = 1'b1; pgm_n = 1'b0; addr = 11'h007; din = 8'h00;
        repeat (2) @(negedge clk);
        chk("R8 inhibit en", {7'd0, dout_en}, 8'd0);
        idle(); @(negedge clk);
        read_word(11'h007, 1'b0, 8'hFF, "R8 inhibit no write");

        // R3 standby with oe low, R4 output disable
        ce_n = 1'b1; oe_n = 1'b0; addr = 11'h005;
        repeat (LAT + 1) @(negedge clk);
        chk("R3 standby en", {7'd0, dout_en}, 8'd0);
        chk("R3 standby dout", dout, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        chk("R4 disable en", {7'd0, dout_en}, 8'd0);
        idle(); @(negedge clk);

        // R9 identification
        read_word(11'h000, 1'b1, 8'h8F, "R9 maker code");
        read_word(11'h001, 1'b1, 8'hC2, "R9 device code");
        read_word(11'h201, 1'b1, 8'hC2, "R9 a9 bit set");
        read_word(11'h005, 1'b1, 8'h24, "R9 other bit selects array");

        // R11 latency after an address change inside a read
        ce_n = 1'b0; oe_n = 1'b0; addr = 11'h006;
        repeat (LAT + 1) @(negedge clk);
        addr = 11'h005;
        @(negedge clk);
        chk("R11 not yet valid", dout, 8'h00);
        chk("R11 still driven", {7'd0, dout_en}, 8'd1);
        repeat (LAT) @(negedge clk);
        chk("R11 valid", dout, 8'h24);
        idle(); @(negedge clk);

        // R10 pulse limit
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = 11'h009; din = 8'hF0; pgm_n = 1'b0;
        repeat (LIMIT) @(negedge clk);
        chk("R10 no err at limit", {7'd0, pulse_err}, 8'd0);
        din = 8'h00;
        repeat (2) @(negedge clk);
        chk("R10 err set", {7'd0, pulse_err}, 8'd1);
        idle(); @(negedge clk);
        read_word(11'h009, 1'b0, 8'hF0, "R10 no write past limit");

        // R12 erase beats a concurrent write, R1 all ones
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = 11'h00A; din = 8'h00;
        pgm_n = 1'b0; erase = 1'b1;
        @(negedge clk);
        idle(); @(negedge clk);
        read_word(11'h00A, 1'b0, 8'hFF, "R12 erase priority");
        read_word(11'h005, 1'b0, 8'hFF, "R1 erased word");
        chk("R10 err held", {7'd0, pulse_err}, 8'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule